// File: doc/BRIEF.md
# Dual-Seed CRC16 Generator and Checker

This block computes a 16-bit CRC one byte per cycle over a packet payload. It serves both directions of a link. On the transmit side, the framer reads the finished CRC and appends it after the payload. On the receive side, the framer feeds the two CRC bytes that follow the payload, and the block reports whether the packet is good.

Two accumulators run side by side from the start of every packet. One starts from a programmable 16-bit seed and the other starts from zero. The transmit side picks which of the two results it sends. The receive side accepts a packet when either result equals the received field, and a two-bit flag shows which seed produced the match.

The generator polynomial is x^16 + x^15 + x^2 + 1. It is processed least significant bit first, so the shift register uses the reflected constant 0xA001.

Top module: `crc16_dual_seed`

## Requirements
- R1: Each byte with `dataValid` high inside a payload is folded into the CRC LSB first with the reflected polynomial 0xA001, one byte per cycle. With the zero seed, the ASCII bytes "123456789" give 0xBB3D.
- R2: A `startStb` loads the configured-seed accumulator from `seedCfg` and the other accumulator from zero. With seed 0xFFFF, "123456789" gives 0x4B37.
- R3: `txCrc` shows the zero-seed accumulator when `txZeroSeed` is 1 and the configured-seed accumulator when it is 0. The framer sends bit 7:0 first.
- R4: A cycle with `dataValid` low leaves both accumulators unchanged. Bytes offered before the first `startStb`, or after the receive check has finished, are ignored.
- R5: After `endStb`, which may come in the same cycle as the last payload byte, the next two valid bytes are taken as the received CRC, low byte then high byte. `checkDone` pulses for exactly one cycle after the edge that takes the high byte. `matchFlags` bit 0 means the configured seed matched and bit 1 means the zero seed matched. `crcPass` is the OR of the two bits. All three results hold until the next `startStb`.
- R6: A `startStb` reloads both accumulators and clears the results in the same cycle, from any phase, including in the middle of a packet. A byte that is valid in the start cycle is folded onto the fresh seeds as the first payload byte.
- R7: A received packet fails when the received field or the payload carries a single-bit error, a double-bit error, an odd number of bit errors, or a burst of up to 16 bits.
- R8: When `seedCfg` is zero, a correct packet sets both bits of `matchFlags`.
- R9: After reset, `txCrc`, `matchFlags`, `crcPass` and `checkDone` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| seedCfg | input | 16 | Programmable seed, sampled on `startStb` |
| txZeroSeed | input | 1 | 1 selects the zero-seed result for `txCrc` |
| startStb | input | 1 | Starts a packet and reloads both accumulators |
| endStb | input | 1 | Marks the end of the payload |
| dataValid | input | 1 | `dataByte` is valid in this cycle |
| dataByte | input | 8 | Payload byte or received CRC byte |
| txCrc | output | 16 | CRC to append; low byte is sent first |
| checkDone | output | 1 | One-cycle pulse when the receive result is ready |
| crcPass | output | 1 | Received CRC matched under at least one seed |
| matchFlags | output | 2 | Bit 0: configured seed matched; bit 1: zero seed matched |

## Verification
The bench compares the engine against two well-known check values, one per seed. A wrong bit order or the unreflected polynomial would miss both. Idle bytes, gaps in `dataValid`, and an `endStb` that arrives together with the last byte are all exercised. A design that folds a stalled byte, or drops the last byte, would report a wrong CRC.

A restart is issued in the middle of a packet, with a byte in the same cycle. A design that kept the old state, or dropped that byte, would fail a packet that is otherwise correct. Packets sealed under the zero seed are checked while a nonzero seed is configured, and a zero configured seed is also tested. A checker that compares only one seed would reject good traffic or report the wrong flag.

The bench also sends corrupted packets: single-bit, double-bit and odd-count errors, a flip in the received field, and a 16-bit burst. Each of these must fail.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CrcW = 16;
  localparam int ByteW = 8;
  localparam logic [CrcW-1:0] PolyRefl = 16'hA001;

  typedef struct packed {
    logic loadSeed;
    logic foldByte;
    logic capLo;
    logic capHi;
  } ctrl_strobes_t;

  function automatic logic [CrcW-1:0] crcFoldByte(input logic [CrcW-1:0] crcIn,
                                                  input logic [ByteW-1:0] din);
    logic [CrcW-1:0] c;
    logic fb;
    c = crcIn;
    for (int i = 0; i < ByteW; i++) begin
      fb = c[0] ^ din[i];
      c = c >> 1;
      if (fb) c = c ^ PolyRefl;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startStb,
  input  logic          endStb,
  input  logic          dataValid,
  output ctrl_strobes_t strobes,
  output logic          checkDone
);
  typedef enum logic [2:0] {PH_IDLE, PH_PAYLOAD, PH_CRCLO, PH_CRCHI, PH_DONE} phase_t;
  phase_t phase, phaseNext;

  always_comb begin
    strobes = '0;
    phaseNext = phase;
    if (startStb) begin
      strobes.loadSeed = 1'b1;
      strobes.foldByte = dataValid;
      phaseNext = endStb ? PH_CRCLO : PH_PAYLOAD;
    end else begin
      case (phase)
        PH_PAYLOAD: begin
          strobes.foldByte = dataValid;
          if (endStb) phaseNext = PH_CRCLO;
        end
        PH_CRCLO: if (dataValid) begin
          strobes.capLo = 1'b1;
          phaseNext = PH_CRCHI;
        end
        PH_CRCHI: if (dataValid) begin
          strobes.capHi = 1'b1;
          phaseNext = PH_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      checkDone <= 1'b0;
    end else begin
      phase <= phaseNext;
      checkDone <= strobes.capHi;
    end
  end
endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int NumSeeds = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobes_t       strobes,
  input  logic [CrcW-1:0]     seedCfg,
  input  logic                txZeroSeed,
  input  logic [ByteW-1:0]    dataByte,
  output logic [CrcW-1:0]     txCrc,
  output logic [NumSeeds-1:0] matchFlags
);
  logic [CrcW-1:0] acc [NumSeeds];
  logic [ByteW-1:0] rxLo;
  logic [CrcW-1:0] rxField;

  assign rxField = {dataByte, rxLo};

  for (genvar g = 0; g < NumSeeds; g++) begin : g_acc
    logic [CrcW-1:0] seedVal;
    assign seedVal = (g == 0) ? seedCfg : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc[g] <= '0;
        matchFlags[g] <= 1'b0;
      end else if (strobes.loadSeed) begin
        acc[g] <= strobes.foldByte ? crcFoldByte(seedVal, dataByte) : seedVal;
        matchFlags[g] <= 1'b0;
      end else begin
        if (strobes.foldByte) acc[g] <= crcFoldByte(acc[g], dataByte);
        if (strobes.capHi) matchFlags[g] <= (acc[g] == rxField);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxLo <= '0;
    else if (strobes.capLo) rxLo <= dataByte;
  end

  assign txCrc = txZeroSeed ? acc[1] : acc[0];
endmodule

// File: rtl/crc16_dual_seed.sv
module crc16_dual_seed
  import crc16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] seedCfg,
  input  logic        txZeroSeed,
  input  logic        startStb,
  input  logic        endStb,
  input  logic        dataValid,
  input  logic [7:0]  dataByte,
  output logic [15:0] txCrc,
  output logic        checkDone,
  output logic        crcPass,
  output logic [1:0]  matchFlags
);
  ctrl_strobes_t strobes;

  crc16_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .endStb(endStb),
    .dataValid(dataValid), .strobes(strobes), .checkDone(checkDone)
  );

  crc16_datapath #(.NumSeeds(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .seedCfg(seedCfg),
    .txZeroSeed(txZeroSeed), .dataByte(dataByte), .txCrc(txCrc),
    .matchFlags(matchFlags)
  );

  assign crcPass = |matchFlags;
endmodule

// File: rtl/crc16_dual_seed_chk.sv
module crc16_dual_seed_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] seedCfg,
  input logic        txZeroSeed,
  input logic        startStb,
  input logic        dataValid,
  input logic [15:0] txCrc,
  input logic        checkDone,
  input logic [1:0]  matchFlags
);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    checkDone |=> !checkDone);

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!checkDone && !$past(startStb)) |-> $stable(matchFlags));

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (matchFlags == 2'b00) && !checkDone);

  assert_seed_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !dataValid) |=> (txZeroSeed != $past(txZeroSeed)) ||
      (txCrc == ($past(txZeroSeed) ? 16'h0000 : $past(seedCfg))));

  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!dataValid && !startStb) |=> (txZeroSeed != $past(txZeroSeed)) || $stable(txCrc));
endmodule

bind crc16_dual_seed crc16_dual_seed_chk u_chk (
  .clk(clk), .rstN(rstN), .seedCfg(seedCfg), .txZeroSeed(txZeroSeed),
  .startStb(startStb), .dataValid(dataValid), .txCrc(txCrc),
  .checkDone(checkDone), .matchFlags(matchFlags)
);

// File: tb/sim_crc16_dual_seed.sv
module sim_crc16_dual_seed;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] seedCfg = '0;
  logic txZeroSeed = 1'b0;
  logic startStb = 1'b0;
  logic endStb = 1'b0;
  logic dataValid = 1'b0;
  logic [7:0] dataByte = '0;
  logic [15:0] txCrc;
  logic checkDone, crcPass;
  logic [1:0] matchFlags;

  int checks = 0;
  int failures = 0;
  logic [7:0] pkt [0:15];
  int pktLen = 0;

  always #10 clk = ~clk;

  crc16_dual_seed u0 (
    .clk(clk), .rstN(rstN), .seedCfg(seedCfg), .txZeroSeed(txZeroSeed),
    .startStb(startStb), .endStb(endStb), .dataValid(dataValid),
    .dataByte(dataByte), .txCrc(txCrc), .checkDone(checkDone),
    .crcPass(crcPass), .matchFlags(matchFlags)
  );

  function automatic logic [15:0] refCrc(input logic [15:0] seed);
    logic [15:0] c = seed;
    for (int k = 0; k < pktLen; k++)
      for (int b = 0; b < 8; b++)
        c = ((c >> 1) ^ (((c[0] ^ pkt[k][b]) != 1'b0) ? 16'hA001 : 16'h0000));
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    startStb = 0; endStb = 0; dataValid = 0; dataByte = '0;
  endtask

  task automatic loadDigits();
    pktLen = 9;
    for (int k = 0; k < 9; k++) pkt[k] = 8'h31 + 8'(k);
  endtask

  // start cycle without data, then payload bytes, endStb with last byte
  task automatic sendPayload(input bit gaps);
    startStb = 1; dataValid = 0; tick();
    idle();
    for (int k = 0; k < pktLen; k++) begin
      if (gaps && k % 3 == 1) begin
        dataValid = 0; dataByte = 8'hA5; tick();
      end
      dataValid = 1; dataByte = pkt[k]; endStb = (k == pktLen - 1); tick();
    end
    idle();
  endtask

  task automatic sendRxCrc(input logic [15:0] rx, input logic [1:0] expFlags, input string req);
    dataValid = 1; dataByte = rx[7:0]; tick();
    chk(checkDone == 0, req, checkDone, 0);
    dataByte = rx[15:8]; tick();
    idle();
    chk(checkDone == 1, req, checkDone, 1);
    chk(matchFlags == expFlags, req, matchFlags, expFlags);
    chk(crcPass == (expFlags != 0), req, crcPass, (expFlags != 0));
    tick();
    chk(checkDone == 0 && matchFlags == expFlags, req, {checkDone, matchFlags}, {1'b0, expFlags});
  endtask

  task automatic t_reset();
    chk(txCrc == 0 && matchFlags == 0 && !crcPass && !checkDone, "R9",
        {txCrc, matchFlags, crcPass, checkDone}, 0);
  endtask

  task automatic t_known_values();
    loadDigits();
    seedCfg = 16'hFFFF; txZeroSeed = 1;
    sendPayload(0);
    chk(txCrc == 16'hBB3D, "R1", txCrc, 16'hBB3D);
    txZeroSeed = 0; #1;
    chk(txCrc == 16'h4B37, "R2", txCrc, 16'h4B37);
    chk(txCrc == refCrc(16'hFFFF), "R3", txCrc, refCrc(16'hFFFF));
  endtask

  task automatic t_gaps_ignored();
    loadDigits();
    seedCfg = 16'h1D0F; txZeroSeed = 0;
    dataValid = 1; dataByte = 8'h77; tick(); tick();   // idle bytes before start
    idle();
    sendPayload(1);
    chk(txCrc == refCrc(16'h1D0F), "R4", txCrc, refCrc(16'h1D0F));
    sendRxCrc(refCrc(16'h1D0F), 2'b01, "R5");
    dataValid = 1; dataByte = 8'h3C; tick(); idle();   // after done: ignored
    chk(txCrc == refCrc(16'h1D0F) && matchFlags == 2'b01, "R4", {txCrc, matchFlags}, {refCrc(16'h1D0F), 2'b01});
  endtask

  task automatic t_zero_seed_rx();
    pktLen = 5;
    for (int k = 0; k < 5; k++) pkt[k] = 8'h10 * 8'(k) + 8'h03;
    seedCfg = 16'h1234;
    sendPayload(0);
    sendRxCrc(refCrc(16'h0000), 2'b10, "R5");
  endtask

  task automatic t_errors();
    logic [15:0] good;
    pktLen = 6;
    for (int k = 0; k < 6; k++) pkt[k] = 8'hC3 ^ 8'(k * 29);
    seedCfg = 16'hBEEF;
    good = refCrc(16'hBEEF);
    sendPayload(0);
    sendRxCrc(good ^ 16'h0100, 2'b00, "R7");          // single bit in field
    pkt[2] = pkt[2] ^ 8'h81;                          // double bit in payload
    sendPayload(0);
    sendRxCrc(good, 2'b00, "R7");
    pkt[2] = pkt[2] ^ 8'h81;
    pkt[4] = pkt[4] ^ 8'h70;                          // odd count: three bits
    sendPayload(0);
    sendRxCrc(good, 2'b00, "R7");
    pkt[4] = pkt[4] ^ 8'h70;
    pkt[1] = pkt[1] ^ 8'hFF; pkt[2] = pkt[2] ^ 8'hFF; // 16-bit burst
    sendPayload(0);
    sendRxCrc(good, 2'b00, "R7");
  endtask

  task automatic t_restart();
    pktLen = 4;
    for (int k = 0; k < 4; k++) pkt[k] = 8'h5A + 8'(k);
    seedCfg = 16'hAAAA;
    startStb = 1; tick(); idle();
    dataValid = 1; dataByte = 8'hEE; tick(); tick(); idle();
    // restart mid-packet with first byte in the start cycle
    startStb = 1; dataValid = 1; dataByte = pkt[0]; tick();
    idle();
    chk(matchFlags == 0 && !checkDone, "R6", matchFlags, 0);
    for (int k = 1; k < 4; k++) begin
      dataValid = 1; dataByte = pkt[k]; endStb = (k == 3); tick();
    end
    idle();
    chk(txCrc == refCrc(16'hAAAA), "R6", txCrc, refCrc(16'hAAAA));
    sendRxCrc(refCrc(16'hAAAA), 2'b01, "R6");
    startStb = 1; tick(); idle();
    chk(matchFlags == 0 && !crcPass, "R6", matchFlags, 0);
  endtask

  task automatic t_both_zero();
    loadDigits();
    seedCfg = 16'h0000;
    sendPayload(0);
    sendRxCrc(16'hBB3D, 2'b11, "R8");
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #5; tick(); tick();
    t_reset();
    rstN = 1; tick();
    t_reset();
    t_known_values();
    t_gaps_ignored();
    t_zero_seed_rx();
    t_errors();
    t_restart();
    t_both_zero();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule